// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit sits beside the integer pipeline of a 32-bit RISC core and carries out the long-latency arithmetic. A request supplies two operands and a 3-bit operation code, and is taken with a one-cycle `start` pulse. The unit then raises `busy`. When the result has been written into the 64-bit HI:LO pair, it drops `busy` and pulses `done`.

The multiply operations produce the full 64-bit product. They can also fold that product into the accumulator held in HI:LO, adding it or subtracting it. The divide operations return the quotient in LO and the remainder in HI. A zero divisor leaves both registers as they were.

HI and LO are always visible on read ports. The requester is expected to hold off reads while `busy` is high. Each register can also be loaded directly through its own write port while the unit is idle.

Top module: `mdu_hilo`

## Requirements
- R1: Operation code `op_code` has the following encoding, with bit 0 set meaning the operands are unsigned (zero-extended) and clear meaning they are signed (sign-extended): 000 multiply, 001 multiply unsigned, 010 multiply-add, 011 multiply-add unsigned, 100 multiply-subtract, 101 multiply-subtract unsigned, 110 divide, 111 divide unsigned. A multiply writes the full 64-bit product, with bits 31:0 going to LO and bits 63:32 going to HI.
- R2: Multiply-add writes the 64-bit sum of the previous HI:LO and the product back into HI:LO, with the result wrapping modulo 2^64.
- R3: Multiply-subtract writes the previous HI:LO minus the product back into HI:LO, with the result wrapping modulo 2^64.
- R4: A divide writes the quotient to LO and the remainder to HI. A signed divide truncates toward zero, and its remainder carries the sign of the dividend.
- R5: A signed divide of 0x80000000 by 0xFFFFFFFF gives a quotient of 0x80000000 and a remainder of 0. No error is flagged.
- R6: A divide with a zero divisor still completes with its normal timing, and leaves HI and LO unchanged.
- R7: `busy` is high from the edge that accepts `start` until `done` pulses. `done` is a single-cycle pulse during which `busy` is low. `done` appears MUL_LAT edges after the accepting edge for the multiply operations (default 2), and 33 edges after it for the divide operations.
- R8: A `start` that arrives while `busy` is high is ignored. It does not alter the running operation and does not begin a new one.
- R9: `hi_we` loads `hi_wdata` into HI and `lo_we` loads `lo_wdata` into LO, each on the next edge, and only when the unit is idle. While `busy` is high, both writes are ignored.
- R10: Reset, which is synchronous and active-low, clears HI, LO, `busy` and `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| op_code | input | 3 | Operation select (see R1) |
| opnd_a | input | 32 | First operand; dividend for divides |
| opnd_b | input | 32 | Second operand; divisor for divides |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi_rd | output | 32 | Current HI value |
| lo_rd | output | 32 | Current LO value |
| hi_we | input | 1 | Direct HI write enable |
| hi_wdata | input | 32 | Direct HI write data |
| lo_we | input | 1 | Direct LO write enable |
| lo_wdata | input | 32 | Direct LO write data |

## Verification
The hardest cases to reach from the ports are a `start` pulse or a direct write that lands in the middle of a running operation. Random operands almost never produce the exact values a divide needs for its corner cases.

The bench therefore runs some operations in a disturbed mode. In that mode it pulses `start` with different operands, or pulses both write enables, on the cycle right after acceptance. It then checks that the final result and the latency match an undisturbed run. The random stream is biased to draw zero and small divisors and the most negative dividend often. Directed cases pin down 0x80000000 divided by -1 and divides of mixed sign.

// File: rtl/mdu_pkg.sv
// Shared operation encoding for the HI/LO multiply-divide unit.
// Bit 0 of every code selects unsigned operands; bits 2:1 pick the class.
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MUL   = 3'b000,
        OP_MULU  = 3'b001,
        OP_MADD  = 3'b010,
        OP_MADDU = 3'b011,
        OP_MSUB  = 3'b100,
        OP_MSUBU = 3'b101,
        OP_DIV   = 3'b110,
        OP_DIVU  = 3'b111
    } mdu_op_e;

endpackage

// File: rtl/mdu_mult.sv
// Pipelined full-width multiplier.
// Forms the 2W-bit product of two W-bit operands, signed or unsigned,
// and delivers it LAT edges after in_valid. Assumes at most one operation
// in flight (the controller holds off new work while busy).
module mdu_mult #(
    parameter int W   = 32,
    parameter int LAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           is_signed,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           out_valid,
    output logic [2*W-1:0] prod
);

    localparam int PW = 2 * W;

    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] bx;
    logic        [PW-1:0] full;
    logic [LAT-1:0]         pipe_v;
    logic [LAT-1:0][PW-1:0] pipe_p;

    // Extend operands to product width according to signedness.
    always_comb begin
        ax   = {{W{is_signed & a[W-1]}}, a};
        bx   = {{W{is_signed & b[W-1]}}, b};
        full = ax * bx;
    end

    // Carry the product and its valid flag down the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_v <= '0;
            pipe_p <= '0;
        end else begin
            pipe_v[0] <= in_valid;
            pipe_p[0] <= full;
            for (int s = 1; s < LAT; s++) begin
                pipe_v[s] <= pipe_v[s-1];
                pipe_p[s] <= pipe_p[s-1];
            end
        end
    end

    assign out_valid = pipe_v[LAT-1];
    assign prod      = pipe_p[LAT-1];

    // R7: only one multiply may be in the pipeline at any time.
    a_r7_mul_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pipe_v));

endmodule

// File: rtl/mdu_div.sv
// Iterative restoring divider.
// Divides magnitudes over W iterations after a load edge, then fixes signs:
// the quotient is negated when the operand signs differ, and the remainder
// follows the dividend. out_valid pulses the cycle after the last iteration.
// A zero divisor yields don't-care results; the controller discards them.
module mdu_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         out_valid,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_r, quo_r, dvs_r;
    logic [CW-1:0] cnt;
    logic          run, neg_q, neg_r, vld;
    logic [W:0]    shifted, diff;
    logic          a_neg, b_neg;

    // One restoring step: shift in the next dividend bit and trial-subtract.
    always_comb begin
        shifted = {rem_r, quo_r[W-1]};
        diff    = shifted - {1'b0, dvs_r};
        a_neg   = is_signed & dividend[W-1];
        b_neg   = is_signed & divisor[W-1];
    end

    // Load magnitudes, then iterate W times and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r <= '0;
            quo_r <= '0;
            dvs_r <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
            vld   <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (load) begin
                rem_r <= '0;
                quo_r <= a_neg ? -dividend : dividend;
                dvs_r <= b_neg ? -divisor : divisor;
                neg_q <= a_neg ^ b_neg;
                neg_r <= a_neg;
                cnt   <= CW'(W);
                run   <= 1'b1;
            end else if (run) begin
                if (!diff[W]) begin
                    rem_r <= diff[W-1:0];
                    quo_r <= {quo_r[W-2:0], 1'b1};
                end else begin
                    rem_r <= shifted[W-1:0];
                    quo_r <= {quo_r[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    vld <= 1'b1;
                end
            end
        end
    end

    assign out_valid = vld;
    assign quo       = neg_q ? -quo_r : quo_r;
    assign rem       = neg_r ? -rem_r : rem_r;

    // R7: the iteration counter never runs out while the divider is active.
    a_r7_div_count: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
    // R7: completion only follows the final iteration, never a live run.
    a_r7_div_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> !run);

endmodule

// File: rtl/mdu_hilo.sv
// HI/LO multiply-divide unit, top level.
// Accepts one operation per start pulse while idle, routes it to the
// multiplier or divider, and commits the result into the HI:LO pair with
// a one-cycle done pulse. Direct HI/LO writes are honoured only while idle.
// Assumes the requester does not read hi_rd/lo_rd while busy is high.
module mdu_hilo
    import mdu_pkg::*;
#(
    parameter int W       = 32,
    parameter int MUL_LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi_rd,
    output logic [W-1:0] lo_rd,
    input  logic         hi_we,
    input  logic [W-1:0] hi_wdata,
    input  logic         lo_we,
    input  logic [W-1:0] lo_wdata
);

    localparam int PW = 2 * W;

    logic          busy_q, done_q, bzero_q;
    mdu_op_e       op_q;
    logic [W-1:0]  hi_q, lo_q;
    logic          accept, req_div, finish;
    logic          mul_vld, div_vld;
    logic [PW-1:0] mul_prod, acc, acc_next;
    logic [W-1:0]  div_quo, div_rem;
    logic          q_is_div;

    // Decode the incoming request and the completion event.
    always_comb begin
        accept   = start & ~busy_q;
        req_div  = op_code[2] & op_code[1];
        q_is_div = (op_q == OP_DIV) || (op_q == OP_DIVU);
        finish   = mul_vld | div_vld;
        acc      = {hi_q, lo_q};
    end

    // Select the new HI:LO value for the multiply family.
    always_comb begin
        unique case (op_q)
            OP_MADD, OP_MADDU: acc_next = acc + mul_prod;
            OP_MSUB, OP_MSUBU: acc_next = acc - mul_prod;
            default:           acc_next = mul_prod;
        endcase
    end

    mdu_mult #(.W(W), .LAT(MUL_LAT)) u_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (accept & ~req_div),
        .is_signed (~op_code[0]),
        .a         (opnd_a),
        .b         (opnd_b),
        .out_valid (mul_vld),
        .prod      (mul_prod)
    );

    mdu_div #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept & req_div),
        .is_signed (~op_code[0]),
        .dividend  (opnd_a),
        .divisor   (opnd_b),
        .out_valid (div_vld),
        .quo       (div_quo),
        .rem       (div_rem)
    );

    // Track the handshake state and the latched operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            op_q    <= OP_MUL;
            bzero_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                busy_q  <= 1'b1;
                op_q    <= mdu_op_e'(op_code);
                bzero_q <= (opnd_b == '0);
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Commit results, or apply direct writes while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (finish) begin
            if (q_is_div) begin
                if (!bzero_q) begin
                    hi_q <= div_rem;
                    lo_q <= div_quo;
                end
            end else begin
                {hi_q, lo_q} <= acc_next;
            end
        end else if (!busy_q) begin
            if (hi_we) hi_q <= hi_wdata;
            if (lo_we) lo_q <= lo_wdata;
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign hi_rd = hi_q;
    assign lo_rd = lo_q;

    // R6: a zero-divisor completion leaves HI and LO as they were.
    a_r6_divzero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && q_is_div && bzero_q) |=> ($stable(hi_q) && $stable(lo_q)));
    // R9: nothing alters HI/LO mid-operation.
    a_r9_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !finish) |=> ($stable(hi_q) && $stable(lo_q)));
    // R7: done is a one-cycle pulse seen only while idle.
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R8: an accepted start always leads to busy.
    a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy_q);
    // R7: the two engines never complete together.
    a_r7_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
        !(mul_vld && div_vld));

endmodule

// File: tb/mdu_hilo_tb.sv
// Self-checking bench for mdu_hilo: directed corner cases plus seeded random.
module mdu_hilo_tb;

    localparam int MUL_LAT = 2;
    localparam int DIV_LAT = 33;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  op_i;
    logic [31:0] a_i, b_i;
    logic        busy, done;
    logic [31:0] hi_rd, lo_rd;
    logic        hi_we, lo_we;
    logic [31:0] hi_wdata, lo_wdata;

    int checks = 0;
    int errors = 0;
    logic [63:0] model = '0;

    always #2 clk = ~clk;

    mdu_hilo #(.W(32), .MUL_LAT(MUL_LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_i),
        .opnd_a(a_i), .opnd_b(b_i), .busy(busy), .done(done),
        .hi_rd(hi_rd), .lo_rd(lo_rd), .hi_we(hi_we), .hi_wdata(hi_wdata),
        .lo_we(lo_we), .lo_wdata(lo_wdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected HI:LO after an operation, from the requirement text.
    function automatic logic [63:0] ref_op(input logic [2:0] o, input logic [31:0] a,
                                           input logic [31:0] b, input logic [63:0] acc);
        logic [63:0] p;
        longint sa, sb, q, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (o[0]) p = {32'b0, a} * {32'b0, b};
        else      p = sa * sb;
        case (o[2:1])
            2'b00: return p;
            2'b01: return acc + p;
            2'b10: return acc - p;
            default: begin
                if (b == 0) return acc;
                if (o[0]) return {a % b, a / b};
                q = sa / sb;
                r = sa % sb;
                return {r[31:0], q[31:0]};
            end
        endcase
    endfunction

    // mode 0: plain; 1: extra start while busy; 2: direct writes while busy.
    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input string tag, input int mode);
        logic [63:0] e;
        int lat, cnt;
        e   = ref_op(o, a, b, model);
        lat = (o[2] & o[1]) ? DIV_LAT : MUL_LAT;
        @(negedge clk);
        start = 1'b1; op_i = o; a_i = a; b_i = b;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        chk({tag, " R7 busy after accept"}, 64'(busy), 64'd1);
        if (mode == 1) begin
            start = 1'b1; op_i = 3'b000; a_i = ~a; b_i = 32'd5;
        end else if (mode == 2) begin
            hi_we = 1'b1; lo_we = 1'b1; hi_wdata = 32'hDEAD_0001; lo_wdata = 32'hDEAD_0002;
        end
        do begin
            @(negedge clk);
            cnt++;
            start = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
        end while (!done && cnt < 100);
        chk({tag, " R7 latency"}, 64'(cnt), 64'(lat));
        chk({tag, " result HI:LO"}, {hi_rd, lo_rd}, e);
        chk({tag, " R7 idle at done"}, 64'(busy), 64'd0);
        model = e;
        if (mode != 0) begin
            @(negedge clk);
            chk({tag, " R8/R9 no follow-on op"}, {62'd0, busy, done}, 64'd0);
            chk({tag, " R8/R9 result kept"}, {hi_rd, lo_rd}, e);
        end
    endtask

    task automatic wr(input logic hw, input logic [31:0] hd, input logic lw, input logic [31:0] ld);
        @(negedge clk);
        hi_we = hw; hi_wdata = hd; lo_we = lw; lo_wdata = ld;
        @(negedge clk);
        hi_we = 1'b0; lo_we = 1'b0;
        if (hw) model[63:32] = hd;
        if (lw) model[31:0]  = ld;
        chk("R9 direct write", {hi_rd, lo_rd}, model);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0]  o;
        logic [31:0] a, b;
        int sel;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; start = 1'b0; op_i = '0; a_i = '0; b_i = '0;
        hi_we = 1'b0; lo_we = 1'b0; hi_wdata = '0; lo_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset HI:LO", {hi_rd, lo_rd}, 64'd0);
        chk("R10 reset busy/done", {62'd0, busy, done}, 64'd0);

        wr(1'b1, 32'h1234_5678, 1'b1, 32'h9ABC_DEF0);
        wr(1'b0, 32'hFFFF_FFFF, 1'b1, 32'h0000_0042);
        wr(1'b1, 32'h0000_00A5, 1'b0, 32'hFFFF_FFFF);

        run_op(3'b000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 mul -1*-1", 0);
        run_op(3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 mulu max", 0);
        run_op(3'b000, 32'h8000_0000, 32'h0000_0003, "R1 mul neg", 0);
        run_op(3'b010, 32'h0001_0000, 32'h0001_0000, "R2 madd", 0);
        run_op(3'b011, 32'hFFFF_FFFF, 32'h0000_0002, "R2 maddu", 0);
        run_op(3'b100, 32'h0000_0007, 32'hFFFF_FFFE, "R3 msub", 0);
        run_op(3'b101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 msubu wrap", 0);
        run_op(3'b110, 32'h0000_0007, 32'hFFFF_FFFE, "R4 div 7/-2", 0);
        run_op(3'b110, 32'hFFFF_FFF9, 32'h0000_0002, "R4 div -7/2", 0);
        run_op(3'b111, 32'hFFFF_FFF9, 32'h0000_0002, "R4 divu", 0);
        run_op(3'b110, 32'h8000_0000, 32'hFFFF_FFFF, "R5 min/-1", 0);
        chk("R5 quotient", 64'(lo_rd), 64'h8000_0000);
        chk("R5 remainder", 64'(hi_rd), 64'd0);
        run_op(3'b110, 32'h1234_5678, 32'h0, "R6 div by zero", 0);
        run_op(3'b111, 32'hFFFF_FFFF, 32'h0, "R6 divu by zero", 0);
        run_op(3'b110, 32'h0000_0064, 32'h0000_0007, "R8 start while busy div", 1);
        run_op(3'b000, 32'h0000_0009, 32'h0000_000B, "R8 start while busy mul", 1);
        run_op(3'b010, 32'h0000_0003, 32'h0000_0004, "R9 write while busy madd", 2);
        run_op(3'b111, 32'h0000_0100, 32'h0000_0003, "R9 write while busy div", 2);

        for (int i = 0; i < 150; i++) begin
            o   = 3'($urandom_range(0, 7));
            a   = $urandom;
            b   = $urandom;
            sel = $urandom_range(0, 9);
            if (sel == 0) b = 32'd0;
            else if (sel == 1) b = 32'($urandom_range(0, 15));
            else if (sel == 2) a = 32'h8000_0000;
            else if (sel == 3) b = 32'hFFFF_FFFF;
            run_op(o, a, b, "R1-style random op", $urandom_range(0, 2));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule